// File: doc/BRIEF.md
# SMBus Configuration Register Bank

This block is a serial-bus slave that lets a system controller read and change a small bank of 8-bit configuration registers. These registers steer a clock generator. The block watches the serial clock and the serial data line of an open-drain two-wire bus and oversamples both with the system clock. Its only bus output is an enable that pulls SDA low. The data and its acknowledge bits are sent through that enable.

A command byte follows the device address. When the command's top bit is 1, the transfer addresses one register, and the low seven bits give its offset. When the top bit is 0, the transfer is a block transfer. A block write carries a byte count and then fills the registers from offset 0 upward. A block read first returns the number of implemented registers and then the registers from offset 0 upward.

Ten registers exist. Some bits are fixed or read-only, and some mirror hardware strap inputs. The read-visible value of every register is always presented on a parallel output, together with decoded controls for frequency selection and for the PLL divider.

Top module: `cfg_smb_regbank`

## Requirements
- R1: The slave answers only the 7-bit address 69h, that is 8-bit D2h for writes and D3h for reads. Any other address gets no acknowledge, and the bytes that follow it have no effect until the next start.
- R2: For every byte the slave receives after a matching address, it pulls SDA low for the whole ninth clock. It changes its SDA drive only while SCL is low.
- R3: Byte write: the address is D2h and the command has bit 7 = 1, with the offset in bits 6:0. The following data byte is stored at that offset.
- R4: Byte read: the address is D2h, then the command with bit 7 = 1, then a repeated start, then D3h. The slave returns the register at the offset, MSB first, and releases the bus after the master's not-acknowledge.
- R5: Block write: the command is 00h. The next byte is a count, which is acknowledged but does not limit the transfer. Data bytes then go to offsets 0, 1, 2 and upward, and a stop after any complete byte ends the transfer without touching later registers.
- R6: Block read: the command is 00h, then a repeated start and D3h. The slave returns 0Ah first and then registers 0, 1, 2 and upward for as long as the master acknowledges. After a not-acknowledge the slave leaves SDA released.
- R7: Reset values, as read: reg1 7Eh, reg2 7Fh, reg3 67h, reg4 CFh, reg5 7Fh, reg6 80h, reg7 00h, reg8 08h, reg9 00h. reg0 is built from the straps as in R9.
- R8: Read-only bits are acknowledged on write and the written value is discarded. These bits are: all of reg8 (always 08h), reg7 bit 7 and reg9 bit 7 (both read 0), and reg0 bits 7 and 2 (both read 0). reg0 bit 0 mirrors the CPU-mode strap.
- R9: reg0 bit 3 is the software-select bit. While it is 0, reg0 bits 1, 6, 5 and 4 follow the frequency straps FS3, FS2, FS1 and FS0, and writes to them are dropped. While it is 1, those bits hold the values written and no longer follow the straps. freq_sel_o always equals {bit1, bit6, bit5, bit4}.
- R10: An offset of 10 or above is acknowledged on write and the data is discarded. A read at such an offset returns 00h.
- R11: div_prog_o is reg9 bit 0, div_n_o is reg7 bits 6:0, and div_r_o is reg9 bits 6:1.
- R12: cfg_o carries the read-visible value of register k in bits 8k+7 down to 8k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| strap_fs_i | input | 4 | Frequency-select strap levels, FS3 to FS0 |
| strap_cpu_mode_i | input | 1 | CPU interface mode strap |
| cfg_o | output | 80 | Read-visible values of all registers |
| freq_sel_o | output | 4 | Effective frequency select |
| div_prog_o | output | 1 | 1 selects the programmed divider values |
| div_n_o | output | 7 | Programmed N divider |
| div_r_o | output | 6 | Programmed R divider |

## Verification
Some rules are checked by assertions on every cycle:
- the slave's SDA drive never changes while SCL is high outside a start or stop;
- a foreign address never leads to an acknowledge;
- an out-of-range write leaves all stored bits unchanged;
- the frequency bits follow the straps one cycle late while software select is off.

Other behaviour only shows in whole bus transactions run by the bench scenarios:
- the byte order of block reads, with the count first;
- a block write cut short by a stop;
- the effect of the software-select bit on later writes;
- read-only bits swallowing written data.

// File: rtl/cfg_smb_pkg.sv
package cfg_smb_pkg;
  localparam int unsigned NUM_REGS = 10;
  localparam int unsigned DW       = 8;
  localparam int unsigned AW       = 7;
  localparam int unsigned CFG_W    = NUM_REGS * DW;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK_RX,
    ST_TX,
    ST_ACK_TX
  } smb_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } smb_phase_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic              scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_d <= scl_q[STAGES-1];
      sda_d <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_evt = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_evt  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/smb_xfer_fsm.sv
module smb_xfer_fsm
  import cfg_smb_pkg::*;
#(
  parameter logic [AW-1:0] DEV_ADDR = 7'h69
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          sda_pull_o
);
  localparam logic [3:0]    BITS_PER_BYTE = 4'd8;
  localparam logic [AW-1:0] PTR_MAX       = '1;

  smb_state_e    state_q, state_d;
  smb_phase_e    phase_q, phase_d;
  logic [3:0]    bit_cnt_q, bit_cnt_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [AW-1:0] ptr_q, ptr_d, ptr_inc;
  logic          blk_q, blk_d;
  logic          rdm_q, rdm_d;
  logic          first_q, first_d;
  logic          mack_q, mack_d;
  logic          byte_done;

  assign ptr_inc   = (ptr_q == PTR_MAX) ? ptr_q : ptr_q + 7'd1;
  assign byte_done = (state_q == ST_RX) && scl_fall && (bit_cnt_q == BITS_PER_BYTE);
  assign rd_addr   = ptr_q;
  assign wr_addr   = ptr_q;
  assign wr_data   = sh_q;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    bit_cnt_d = bit_cnt_q;
    sh_d      = sh_q;
    ptr_d     = ptr_q;
    blk_d     = blk_q;
    rdm_d     = rdm_q;
    first_d   = first_q;
    mack_d    = mack_q;
    wr_en     = 1'b0;
    if (stop_evt) begin
      state_d = ST_IDLE;
    end else if (start_evt) begin
      state_d   = ST_RX;
      phase_d   = PH_ADDR;
      bit_cnt_d = '0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && bit_cnt_q != BITS_PER_BYTE) begin
            sh_d      = {sh_q[DW-2:0], sda_s};
            bit_cnt_d = bit_cnt_q + 4'd1;
          end else if (byte_done) begin
            bit_cnt_d = '0;
            state_d   = ST_ACK_RX;
            case (phase_q)
              PH_ADDR: begin
                if (sh_q[DW-1:1] == DEV_ADDR) begin
                  rdm_d   = sh_q[0];
                  first_d = sh_q[0];
                  if (!sh_q[0]) phase_d = PH_CMD;
                end else begin
                  state_d = ST_IDLE;
                end
              end
              PH_CMD: begin
                blk_d   = ~sh_q[DW-1];
                ptr_d   = sh_q[DW-1] ? sh_q[AW-1:0] : '0;
                phase_d = sh_q[DW-1] ? PH_DATA : PH_CNT;
              end
              PH_CNT:  phase_d = PH_DATA;
              default: begin
                wr_en = 1'b1;
                ptr_d = ptr_inc;
              end
            endcase
          end
        end
        ST_ACK_RX: begin
          if (scl_fall) begin
            if (rdm_q && phase_q == PH_ADDR) begin
              state_d   = ST_TX;
              bit_cnt_d = '0;
              first_d   = 1'b0;
              if (first_q && blk_q) begin
                sh_d = 8'(NUM_REGS);
              end else begin
                sh_d  = rd_data;
                ptr_d = ptr_inc;
              end
            end else begin
              state_d = ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bit_cnt_q == 4'd7) begin
              state_d   = ST_ACK_TX;
              bit_cnt_d = '0;
            end else begin
              sh_d      = {sh_q[DW-2:0], 1'b0};
              bit_cnt_d = bit_cnt_q + 4'd1;
            end
          end
        end
        ST_ACK_TX: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d   = ST_TX;
              bit_cnt_d = '0;
              sh_d      = rd_data;
              ptr_d     = ptr_inc;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_ADDR;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      ptr_q     <= '0;
      blk_q     <= 1'b0;
      rdm_q     <= 1'b0;
      first_q   <= 1'b0;
      mack_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      bit_cnt_q <= bit_cnt_d;
      sh_q      <= sh_d;
      ptr_q     <= ptr_d;
      blk_q     <= blk_d;
      rdm_q     <= rdm_d;
      first_q   <= first_d;
      mack_q    <= mack_d;
    end
  end

  assign sda_pull_o = (state_q == ST_ACK_RX) || ((state_q == ST_TX) && !sh_q[DW-1]);

  // R2: slave drive changes only while SCL is low
  a_r2_sda_stable_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_pull_o))
    else $error("R2: SDA drive changed while SCL high");

  // R1: no acknowledge for a foreign address
  a_r1_no_ack_foreign: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && phase_q == PH_ADDR && sh_q[DW-1:1] != DEV_ADDR && !start_evt && !stop_evt)
      |=> !sda_pull_o)
    else $error("R1: foreign address acknowledged");
endmodule

// File: rtl/cfg_reg_store.sv
module cfg_reg_store
  import cfg_smb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [AW-1:0]    rd_addr,
  input  logic [3:0]       strap_fs_i,
  input  logic             strap_cpu_mode_i,
  output logic [DW-1:0]    rd_data,
  output logic [CFG_W-1:0] cfg_flat,
  output logic [3:0]       freq_sel,
  output logic             div_prog,
  output logic [6:0]       div_n,
  output logic [5:0]       div_r
);
  localparam int unsigned GP_LO   = 1;
  localparam int unsigned GP_HI   = 6;
  localparam int unsigned IDX_CTL = 0;
  localparam int unsigned IDX_N   = 7;
  localparam int unsigned IDX_SIG = 8;
  localparam int unsigned IDX_R   = 9;
  localparam logic [DW-1:0] SIG_VAL = 8'h08;

  function automatic logic [DW-1:0] gp_default(input int unsigned idx);
    case (idx)
      1:       return 8'h7E;
      2:       return 8'h7F;
      3:       return 8'h67;
      4:       return 8'hCF;
      5:       return 8'h7F;
      6:       return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  logic [GP_HI:GP_LO][DW-1:0] gp_q;
  logic                       fs_we_q;
  logic [3:0]                 fs_q;
  logic [6:0]                 n_q;
  logic [6:0]                 r9_q;
  logic [DW-1:0]              view [NUM_REGS];
  logic                       wr_ctl, wr_n, wr_r;

  assign wr_ctl = wr_en && (wr_addr == 7'(IDX_CTL));
  assign wr_n   = wr_en && (wr_addr == 7'(IDX_N));
  assign wr_r   = wr_en && (wr_addr == 7'(IDX_R));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = GP_LO; k <= GP_HI; k++) gp_q[k] <= gp_default(k);
    end else begin
      for (int k = GP_LO; k <= GP_HI; k++)
        if (wr_en && wr_addr == 7'(k)) gp_q[k] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fs_we_q <= 1'b0;
      fs_q    <= '0;
      n_q     <= '0;
      r9_q    <= '0;
    end else begin
      if (wr_ctl) fs_we_q <= wr_data[3];
      if (!fs_we_q)    fs_q <= strap_fs_i;
      else if (wr_ctl) fs_q <= {wr_data[1], wr_data[6:4]};
      if (wr_n) n_q  <= wr_data[6:0];
      if (wr_r) r9_q <= wr_data[6:0];
    end
  end

  always_comb begin
    for (int k = 0; k < NUM_REGS; k++) view[k] = '0;
    view[IDX_CTL] = {1'b0, fs_q[2:0], fs_we_q, 1'b0, fs_q[3], strap_cpu_mode_i};
    for (int k = GP_LO; k <= GP_HI; k++) view[k] = gp_q[k];
    view[IDX_N]   = {1'b0, n_q};
    view[IDX_SIG] = SIG_VAL;
    view[IDX_R]   = {1'b0, r9_q};
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (rd_addr == 7'(k)) rd_data = view[k];
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfg_flat[g*DW +: DW] = view[g];
  end

  assign freq_sel = fs_q;
  assign div_prog = r9_q[0];
  assign div_r    = r9_q[6:1];
  assign div_n    = n_q;

  // R9: strap tracking while software select is off
  a_r9_fs_track: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !fs_we_q && !$past(fs_we_q)) |-> (fs_q == $past(strap_fs_i)))
    else $error("R9: frequency bits do not follow straps");

  // R10: out-of-range write leaves storage untouched
  a_r10_oob_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr >= 7'(NUM_REGS)) |=>
      ($stable(gp_q) && $stable(n_q) && $stable(r9_q) && $stable(fs_we_q)))
    else $error("R10: out-of-range write changed storage");
endmodule

// File: rtl/cfg_smb_regbank.sv
module cfg_smb_regbank
  import cfg_smb_pkg::*;
#(
  parameter logic [AW-1:0] DEV_ADDR    = 7'h69,
  parameter int unsigned   SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  input  logic [3:0]       strap_fs_i,
  input  logic             strap_cpu_mode_i,
  output logic [CFG_W-1:0] cfg_o,
  output logic [3:0]       freq_sel_o,
  output logic             div_prog_o,
  output logic [6:0]       div_n_o,
  output logic [5:0]       div_r_o
);
  logic [1:0]    rst_pipe_q;
  logic          rst_n_int;
  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic          wr_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n_int), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  smb_xfer_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n_int), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_evt(start_evt),
    .stop_evt(stop_evt), .rd_data(rd_data), .rd_addr(rd_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_pull_o(sda_pull_o)
  );

  cfg_reg_store u_regs (
    .clk(clk), .rst_n(rst_n_int), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .strap_fs_i(strap_fs_i),
    .strap_cpu_mode_i(strap_cpu_mode_i), .rd_data(rd_data), .cfg_flat(cfg_o),
    .freq_sel(freq_sel_o), .div_prog(div_prog_o), .div_n(div_n_o), .div_r(div_r_o)
  );
endmodule

// File: tb/cfg_smb_regbank_tb.sv
`timescale 1ns/100ps
module cfg_smb_regbank_tb;
  localparam int Q = 8;
  localparam logic [7:0] AW8 = 8'hD2;
  localparam logic [7:0] AR8 = 8'hD3;
  // {offset, write data, expected read}
  localparam logic [22:0] VEC [10] = '{
    {7'h01, 8'hA5, 8'hA5}, {7'h06, 8'h3C, 8'h3C}, {7'h07, 8'hFF, 8'h7F},
    {7'h08, 8'h00, 8'h08}, {7'h09, 8'hFF, 8'h7F}, {7'h00, 8'hFF, 8'h2B},
    {7'h00, 8'h5A, 8'h5B}, {7'h00, 8'h00, 8'h23}, {7'h14, 8'h55, 8'h00},
    {7'h7F, 8'h12, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull;
  logic [3:0] strap_fs = 4'hA;
  logic strap_mode = 1'b1;
  logic [79:0] cfg;
  logic [3:0] freq_sel;
  logic div_prog;
  logic [6:0] div_n;
  logic [5:0] div_r;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  cfg_smb_regbank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .strap_fs_i(strap_fs), .strap_cpu_mode_i(strap_mode), .cfg_o(cfg),
    .freq_sel_o(freq_sel), .div_prog_o(div_prog), .div_n_o(div_n), .div_r_o(div_r)
  );

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qwait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait(1);
    scl = 1'b1;   qwait(1);
    sda_m = 1'b0; qwait(1);
    scl = 1'b0;   qwait(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait(1);
    scl = 1'b1;   qwait(1);
    sda_m = 1'b1; qwait(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; qwait(1);
      scl = 1'b1;   qwait(2);
      scl = 1'b0;   qwait(1);
    end
    sda_m = 1'b1; qwait(1);
    scl = 1'b1;   qwait(1);
    ack = ~sda_line; qwait(1);
    scl = 1'b0;   qwait(1);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qwait(1);
      scl = 1'b1; qwait(1);
      b[i] = sda_line; qwait(1);
      scl = 1'b0;
    end
    qwait(1);
    sda_m = give_ack ? 1'b0 : 1'b1; qwait(1);
    scl = 1'b1; qwait(2);
    scl = 1'b0; qwait(1);
    sda_m = 1'b1;
  endtask

  task automatic byte_write(input logic [6:0] off, input logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(AW8, a0);
    send_byte({1'b1, off}, a1);
    send_byte(d, a2);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  task automatic byte_read(input logic [6:0] off, output logic [7:0] d, output bit ok);
    bit a0, a1, a2;
    bus_start();
    send_byte(AW8, a0);
    send_byte({1'b1, off}, a1);
    bus_start();
    send_byte(AR8, a2);
    recv_byte(1'b0, d);
    bus_stop();
    ok = a0 & a1 & a2;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ok, a;
    logic [7:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);

    // R7 reset view, R9 strap mirror, R11 divider
    chk("R7 reset values", cfg, 80'h00_08_00_80_7F_CF_67_7F_7E_23);
    chk("R7 bus released", sda_pull, 1'b0);
    chk("R9 freq from straps", freq_sel, 4'hA);
    chk("R11 divider select reset", div_prog, 1'b0);

    // table: R3 write, R4 read back, R8 read-only, R9 select bit, R10 range
    for (int i = 0; i < 10; i++) begin
      byte_write(VEC[i][22:16], VEC[i][15:8], ok);
      chk($sformatf("R2 ack row %0d", i), ok, 1'b1);
      byte_read(VEC[i][22:16], d, ok);
      chk($sformatf("R2 read ack row %0d", i), ok, 1'b1);
      chk($sformatf("R3 R4 R8 R9 R10 row %0d", i), d, VEC[i][7:0]);
    end

    chk("R11 div_prog", div_prog, 1'b1);
    chk("R11 div_n", div_n, 7'h7F);
    chk("R11 div_r", div_r, 6'h3F);
    chk("R12 cfg byte1", cfg[15:8], 8'hA5);
    chk("R12 cfg byte8", cfg[71:64], 8'h08);

    // R9 software select sequence
    byte_write(7'h00, 8'h08, ok);
    chk("R9 enable keeps strap", freq_sel, 4'hA);
    byte_write(7'h00, 8'h5A, ok);
    chk("R9 written freq", freq_sel, 4'hD);
    strap_fs = 4'h3;
    repeat (10) @(negedge clk);
    chk("R9 strap ignored while selected", freq_sel, 4'hD);
    byte_write(7'h00, 8'h00, ok);
    repeat (10) @(negedge clk);
    chk("R9 back to strap", freq_sel, 4'h3);
    chk("R9 reg0 view", cfg[7:0], 8'h31);
    strap_fs = 4'hA;
    repeat (10) @(negedge clk);

    // R1 foreign address
    bus_start();
    send_byte(8'hA0, a);
    chk("R1 foreign addr no ack", a, 1'b0);
    send_byte(8'h81, a);
    chk("R1 following byte no ack", a, 1'b0);
    send_byte(8'h00, a);
    bus_stop();
    chk("R1 reg1 untouched", cfg[15:8], 8'hA5);

    // R6 block read
    bus_start();
    send_byte(AW8, a);
    send_byte(8'h00, a);
    bus_start();
    send_byte(AR8, a);
    chk("R6 read address ack", a, 1'b1);
    recv_byte(1'b1, d); chk("R6 count", d, 8'h0A);
    recv_byte(1'b1, d); chk("R6 reg0", d, 8'h23);
    recv_byte(1'b1, d); chk("R6 reg1", d, 8'hA5);
    recv_byte(1'b0, d); chk("R6 reg2", d, 8'h7F);
    bus_stop();
    repeat (10) @(negedge clk);
    chk("R6 released after nack", sda_pull, 1'b0);

    // R5 block write
    bus_start();
    send_byte(AW8, a);
    send_byte(8'h00, a);
    send_byte(8'h03, a);
    chk("R5 count ack", a, 1'b1);
    send_byte(8'h08, a);
    send_byte(8'h3C, a);
    send_byte(8'hC3, a);
    chk("R5 data ack", a, 1'b1);
    bus_stop();
    chk("R5 reg0", cfg[7:0], 8'h2B);
    chk("R5 reg1", cfg[15:8], 8'h3C);
    chk("R5 reg2", cfg[23:16], 8'hC3);
    chk("R5 reg3 untouched", cfg[31:24], 8'h67);

    // R5 early stop: count larger than bytes sent
    bus_start();
    send_byte(AW8, a);
    send_byte(8'h00, a);
    send_byte(8'h05, a);
    send_byte(8'h00, a);
    send_byte(8'h11, a);
    bus_stop();
    chk("R5 short reg1", cfg[15:8], 8'h11);
    chk("R5 short reg2 kept", cfg[23:16], 8'hC3);
    chk("R5 short reg0", cfg[7:0], 8'h23);

    // R4 byte reads after block traffic
    byte_read(7'h03, d, ok);
    chk("R4 reg3", d, 8'h67);
    byte_read(7'h08, d, ok);
    chk("R8 signature", d, 8'h08);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule